// File: doc/BRIEF.md
# Load-Use Interlock and Branch Redirect Flush Controller

This block is the hazard controller at the front of an in-order pipeline. It watches the register source fields of the instruction in decode and the destination of the instruction in execute. When the execute-stage instruction is a load whose result a decode-stage operand needs, the loaded value cannot reach the consumer through forwarding in time. The block then freezes the program counter and the fetch/decode register for one cycle and turns the decode/execute slot into a no-op. Dependencies on results that do not come from memory are left to the forwarding network and cause no stall.

The same unit handles branches under a predict-not-taken policy. Fetch runs sequentially past every branch. When the execute stage reports that a branch resolved as taken, every younger pipeline register named in the flush vector is cleared in that cycle. When a redirect and an interlock occur together, the redirect wins. A small internal state bit ensures that an interlock never lasts longer than one cycle.

Top module: `load_use_flush_ctrl`

## Requirements
- R1: While rst_n is low, pc_hold, ifid_hold, idex_bubble and every flush bit are 0, whatever the other inputs are.
- R2: When ex_valid, ex_mem_rd and id_valid are 1, ex_dst is nonzero, and some source i has id_src_used[i]=1 and id_src[i]==ex_dst, pc_hold, ifid_hold and idex_bubble all go to 1 in that same cycle. This applies when ex_br_taken is 0 and the previous cycle did not stall.
- R3: A matching source whose producer in execute is not a load (ex_mem_rd=0) causes no stall.
- R4: A load whose destination is register 0 never causes a stall, even when a used source field is 0.
- R5: No stall occurs when the matching source has id_src_used=0, or when id_valid or ex_valid is 0.
- R6: The cycle after a stall cycle never stalls, even if the hazard inputs are held unchanged. A third cycle with the same inputs stalls again.
- R7: When ex_br_taken is 1, all NFLUSH flush bits are 1 in the same cycle. Bit 0 clears the fetch/decode register and bit 1 clears the decode/execute register. When ex_br_taken is 0, all flush bits are 0.
- R8: When ex_br_taken is 1, pc_hold, ifid_hold and idex_bubble are 0 even if a load-use hazard is present. A hazard suppressed this way does not count as a stall for R6.
- R9: Each source position is checked on its own terms: a match on the second source alone stalls just as a match on the first does.
- R10: Over an instruction stream, exactly one stall cycle occurs for each load that is directly followed by an instruction using its nonzero destination, and no stall occurs anywhere else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_src | input | NSRC*RW | Source register numbers of the decode instruction, one field per source |
| id_src_used | input | NSRC | Per source: 1 when the instruction actually reads that field |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_mem_rd | input | 1 | Execute instruction reads data memory (a load) |
| ex_dst | input | RW | Destination register of the execute instruction |
| ex_br_taken | input | 1 | Branch in execute resolved taken (misprediction under not-taken policy) |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged this cycle |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |
| flush | output | NFLUSH | Clear younger pipeline registers; bit 0 fetch/decode, bit 1 decode/execute |

## Verification
The hardest situation to reach is the same load-use pair presented on two consecutive cycles. A correct pipeline never produces it, because the bubble replaces the load in execute. To check the one-cycle limit, the stimulus therefore holds the hazard inputs frozen across three cycles, which no real pipeline would do. A hazard that coincides with a taken branch is forced in the same direct way, and the bench then checks that the next cycle still stalls. The stream-level check runs a small pipeline model in the bench that reacts to the hold outputs. It counts stall cycles over a program that contains dependent loads, register-0 loads, and dependencies on non-load results.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int unsigned REG_W_DEF  = 5;
  localparam int unsigned SRCS_DEF   = 2;
  localparam int unsigned KILLS_DEF  = 2;

  typedef enum logic [1:0] {
    ACT_RUN   = 2'd0,
    ACT_STALL = 2'd1,
    ACT_FLUSH = 2'd2
  } ctl_act_e;

  function automatic ctl_act_e pick_action(input logic redirect, input logic interlock);
    if (redirect)       return ACT_FLUSH;
    else if (interlock) return ACT_STALL;
    else                return ACT_RUN;
  endfunction
endpackage

// File: rtl/src_match.sv
module src_match #(
  parameter int unsigned RW = 5
) (
  input  logic [RW-1:0] src,
  input  logic          used,
  input  logic [RW-1:0] dst,
  output logic          hit
);
  always_comb begin
    hit = used && (src == dst);
  end
endmodule

// File: rtl/luse_interlock.sv
module luse_interlock #(
  parameter int unsigned NSRC = 2,
  parameter int unsigned RW   = 5
) (
  input  logic                      id_valid,
  input  logic [NSRC-1:0][RW-1:0]   id_src,
  input  logic [NSRC-1:0]           id_src_used,
  input  logic                      ex_valid,
  input  logic                      ex_mem_rd,
  input  logic [RW-1:0]             ex_dst,
  output logic                      hazard
);
  logic [NSRC-1:0] hits;
  logic            producer_late;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    src_match #(.RW(RW)) u_match (
      .src  (id_src[g]),
      .used (id_src_used[g]),
      .dst  (ex_dst),
      .hit  (hits[g])
    );
  end

  always_comb begin
    producer_late = ex_valid && ex_mem_rd && (ex_dst != '0);
    hazard        = producer_late && id_valid && (|hits);
  end
endmodule

// File: rtl/redirect_flush.sv
module redirect_flush #(
  parameter int unsigned NFLUSH = 2
) (
  input  logic              kill,
  output logic [NFLUSH-1:0] flush
);
  for (genvar g = 0; g < NFLUSH; g++) begin : g_stage
    assign flush[g] = kill;
  end
endmodule

// File: rtl/load_use_flush_ctrl.sv
module load_use_flush_ctrl
  import hzd_pkg::*;
#(
  parameter int unsigned NSRC   = SRCS_DEF,
  parameter int unsigned RW     = REG_W_DEF,
  parameter int unsigned NFLUSH = KILLS_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    id_valid,
  input  logic [NSRC-1:0][RW-1:0] id_src,
  input  logic [NSRC-1:0]         id_src_used,
  input  logic                    ex_valid,
  input  logic                    ex_mem_rd,
  input  logic [RW-1:0]           ex_dst,
  input  logic                    ex_br_taken,
  output logic                    pc_hold,
  output logic                    ifid_hold,
  output logic                    idex_bubble,
  output logic [NFLUSH-1:0]       flush
);
  logic              hazard;
  logic              stall_q;
  logic              stall_d;
  logic              stall_en;
  logic              kill;
  logic [NFLUSH-1:0] flush_raw;
  ctl_act_e          act;

  luse_interlock #(.NSRC(NSRC), .RW(RW)) u_interlock (
    .id_valid    (id_valid),
    .id_src      (id_src),
    .id_src_used (id_src_used),
    .ex_valid    (ex_valid),
    .ex_mem_rd   (ex_mem_rd),
    .ex_dst      (ex_dst),
    .hazard      (hazard)
  );

  // Next-state logic: a stall already taken last cycle blocks a repeat.
  always_comb begin
    act      = pick_action(ex_br_taken, hazard && !stall_q);
    stall_d  = (act == ACT_STALL);
    stall_en = 1'b1;
    kill     = rst_n && (act == ACT_FLUSH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stall_q <= 1'b0;
    else if (stall_en) stall_q <= stall_d;
  end

  redirect_flush #(.NFLUSH(NFLUSH)) u_redirect (
    .kill  (kill),
    .flush (flush_raw)
  );

  always_comb begin
    pc_hold     = rst_n && stall_d;
    ifid_hold   = rst_n && stall_d;
    idex_bubble = rst_n && stall_d;
    flush       = flush_raw;
  end
endmodule

// File: rtl/load_use_flush_chk.sv
module load_use_flush_chk #(
  parameter int unsigned RW     = 5,
  parameter int unsigned NFLUSH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ex_valid,
  input logic              ex_mem_rd,
  input logic [RW-1:0]     ex_dst,
  input logic              ex_br_taken,
  input logic              pc_hold,
  input logic              ifid_hold,
  input logic              idex_bubble,
  input logic [NFLUSH-1:0] flush
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !pc_hold && !ifid_hold && (flush == '0)); // R1
  AST_HOLDS_AGREE: assert property (@(posedge clk) disable iff (!rst_n) (pc_hold == ifid_hold) && (pc_hold == idex_bubble)); // R2
  AST_ALU_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n) !(ex_valid && ex_mem_rd) |-> !pc_hold); // R3
  AST_R0_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n) (ex_dst == '0) |-> !pc_hold); // R4
  AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (!rst_n) pc_hold |=> !pc_hold); // R6
  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n) ex_br_taken |-> (&flush)); // R7
  AST_FLUSH_ONLY_ON_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) !ex_br_taken |-> (flush == '0)); // R7
  AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n) ex_br_taken |-> !pc_hold && !idex_bubble); // R8
endmodule

bind load_use_flush_ctrl load_use_flush_chk #(.RW(RW), .NFLUSH(NFLUSH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ex_valid    (ex_valid),
  .ex_mem_rd   (ex_mem_rd),
  .ex_dst      (ex_dst),
  .ex_br_taken (ex_br_taken),
  .pc_hold     (pc_hold),
  .ifid_hold   (ifid_hold),
  .idex_bubble (idex_bubble),
  .flush       (flush)
);

// File: tb/load_use_flush_ctrl_test.sv
module load_use_flush_ctrl_test;
  localparam int unsigned NSRC = 2;
  localparam int unsigned RW = 5;
  localparam int unsigned NFLUSH = 2;

  logic                    clk;
  logic                    rst_n;
  logic                    id_valid;
  logic [NSRC-1:0][RW-1:0] id_src;
  logic [NSRC-1:0]         id_src_used;
  logic                    ex_valid;
  logic                    ex_mem_rd;
  logic [RW-1:0]           ex_dst;
  logic                    ex_br_taken;
  logic                    pc_hold;
  logic                    ifid_hold;
  logic                    idex_bubble;
  logic [NFLUSH-1:0]       flush;

  int n_cmp = 0;
  int n_bad = 0;

  load_use_flush_ctrl #(.NSRC(NSRC), .RW(RW), .NFLUSH(NFLUSH)) uut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive at the falling edge; outputs are sampled 2 ns later.
  task automatic drive(input logic idv, input int s0, input int s1, input logic u0,
                       input logic u1, input logic exv, input logic ld, input int dst,
                       input logic br);
    @(negedge clk);
    id_valid = idv; id_src[0] = RW'(s0); id_src[1] = RW'(s1);
    id_src_used[0] = u0; id_src_used[1] = u1;
    ex_valid = exv; ex_mem_rd = ld; ex_dst = RW'(dst); ex_br_taken = br;
    #2;
  endtask

  task automatic idle();
    drive(1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0);
  endtask

  function automatic int stall3();
    return (pc_hold && ifid_hold && idex_bubble) ? 1 : (!pc_hold && !ifid_hold && !idex_bubble) ? 0 : 9;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    drive(1'b1, 3, 3, 1'b1, 1'b1, 1'b1, 1'b1, 3, 1'b1);
    check("R1 holds in reset", int'(pc_hold) + int'(ifid_hold) + int'(idex_bubble), 0);
    check("R1 flush in reset", int'(flush), 0);
    @(negedge clk); rst_n = 1'b1;
    idle();
    check("R1 idle after reset", stall3(), 0);
  endtask

  task automatic t_load_use();
    drive(1'b1, 7, 2, 1'b1, 1'b1, 1'b1, 1'b1, 7, 1'b0);
    check("R2 src0 load-use stalls", stall3(), 1);
    check("R2 no flush on stall", int'(flush), 0);
    idle();
    drive(1'b1, 4, 9, 1'b1, 1'b1, 1'b1, 1'b1, 9, 1'b0);
    check("R9 src1 load-use stalls", stall3(), 1);
    idle();
  endtask

  task automatic t_no_stall_cases();
    drive(1'b1, 6, 1, 1'b1, 1'b1, 1'b1, 1'b0, 6, 1'b0);
    check("R3 alu producer no stall", stall3(), 0);
    drive(1'b1, 0, 0, 1'b1, 1'b1, 1'b1, 1'b1, 0, 1'b0);
    check("R4 load to r0 no stall", stall3(), 0);
    drive(1'b1, 5, 2, 1'b0, 1'b1, 1'b1, 1'b1, 5, 1'b0);
    check("R5 unused source no stall", stall3(), 0);
    drive(1'b0, 5, 5, 1'b1, 1'b1, 1'b1, 1'b1, 5, 1'b0);
    check("R5 invalid decode no stall", stall3(), 0);
    drive(1'b1, 5, 5, 1'b1, 1'b1, 1'b0, 1'b1, 5, 1'b0);
    check("R5 invalid execute no stall", stall3(), 0);
  endtask

  task automatic t_single_stall();
    for (int k = 0; k < 3; k++) begin
      drive(1'b1, 12, 12, 1'b1, 1'b0, 1'b1, 1'b1, 12, 1'b0);
      check($sformatf("R6 frozen hazard cycle %0d", k), stall3(), (k == 1) ? 0 : 1);
    end
    idle();
  endtask

  task automatic t_redirect();
    drive(1'b1, 1, 2, 1'b1, 1'b1, 1'b1, 1'b0, 3, 1'b1);
    check("R7 taken branch flushes all", int'(flush), (1 << NFLUSH) - 1);
    check("R7 no hold on plain flush", stall3(), 0);
    drive(1'b1, 8, 0, 1'b1, 1'b0, 1'b1, 1'b1, 8, 1'b1);
    check("R8 flush beats stall holds", stall3(), 0);
    check("R8 flush beats stall flush", int'(flush), (1 << NFLUSH) - 1);
    drive(1'b1, 8, 0, 1'b1, 1'b0, 1'b1, 1'b1, 8, 1'b0);
    check("R8 suppressed hazard not counted", stall3(), 1);
    check("R7 flush low without branch", int'(flush), 0);
    idle();
  endtask

  // Small pipeline model reacting to the holds; counts stall cycles.
  task automatic t_stream();
    localparam int N = 10;
    int ld[N], dd[N], sa[N], sb[N], ua[N], ub[N];
    int id_i, ex_i, stalls, cyc;
    //           ld dst s1 s2 u1 u2
    ld[0]=1; dd[0]=3; sa[0]=1; sb[0]=0; ua[0]=1; ub[0]=0;
    ld[1]=0; dd[1]=4; sa[1]=3; sb[1]=1; ua[1]=1; ub[1]=1;
    ld[2]=0; dd[2]=5; sa[2]=4; sb[2]=3; ua[2]=1; ub[2]=1;
    ld[3]=1; dd[3]=6; sa[3]=2; sb[3]=0; ua[3]=1; ub[3]=0;
    ld[4]=0; dd[4]=7; sa[4]=2; sb[4]=6; ua[4]=1; ub[4]=1;
    ld[5]=1; dd[5]=0; sa[5]=2; sb[5]=0; ua[5]=1; ub[5]=0;
    ld[6]=0; dd[6]=9; sa[6]=0; sb[6]=0; ua[6]=1; ub[6]=1;
    ld[7]=1; dd[7]=8; sa[7]=1; sb[7]=0; ua[7]=1; ub[7]=0;
    ld[8]=0; dd[8]=9; sa[8]=1; sb[8]=8; ua[8]=1; ub[8]=0;
    ld[9]=1; dd[9]=2; sa[9]=2; sb[9]=2; ua[9]=1; ub[9]=1;
    id_i = 0; ex_i = -1; stalls = 0; cyc = 0;
    while ((id_i < N || ex_i >= 0) && cyc < 40) begin
      if (id_i < N && ex_i >= 0)
        drive(1'b1, sa[id_i], sb[id_i], 1'(ua[id_i]), 1'(ub[id_i]), 1'b1, 1'(ld[ex_i]), dd[ex_i], 1'b0);
      else if (id_i < N)
        drive(1'b1, sa[id_i], sb[id_i], 1'(ua[id_i]), 1'(ub[id_i]), 1'b0, 1'b0, 0, 1'b0);
      else
        drive(1'b0, 0, 0, 1'b0, 1'b0, 1'b1, 1'(ld[ex_i]), dd[ex_i], 1'b0);
      if (pc_hold) begin
        stalls++;
        ex_i = -1;
      end else begin
        ex_i = (id_i < N) ? id_i : -1;
        id_i++;
      end
      cyc++;
    end
    // Pairs 0->1 and 3->4 stall; r0 load, unused match, last load do not.
    check("R10 stall cycles over stream", stalls, 2);
    check("R10 stream length", cyc, N + 2 + 1);
    idle();
  endtask

  initial begin
    rst_n = 1'b0; id_valid = 1'b0; id_src = '0; id_src_used = '0;
    ex_valid = 1'b0; ex_mem_rd = 1'b0; ex_dst = '0; ex_br_taken = 1'b0;
    t_reset();
    t_load_use();
    t_no_stall_cases();
    t_single_stall();
    t_redirect();
    t_stream();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule